// File: doc/BRIEF.md
# Code-Cancelled Countdown Timer

This block is a two-mode event timer. In its preset mode the up and down buttons move a count of seconds between fixed limits. Pressing arm starts the countdown. In the countdown mode the same two buttons no longer touch the count. Each press instead shifts one bit into an 8-bit code register: up enters a 1 and down enters a 0. A press of arm while the code equals a build-time cancel value stops the countdown. If the countdown is not cancelled it reaches zero, raises a one-cycle expiry pulse, and returns to preset mode with the count reloaded.

Every event arrives as a single-cycle strobe. A tick strobe comes ten times per second and carries a fine sub-second value that runs from 0 to 9. Only a tick whose fine value is 0 counts off a whole second. The current count is a registered output, so a display can follow it.

Top module: `cancel_countdown`

## Requirements
- R1: After reset the count output is 10, the timing output is 0 (preset mode) and the expiry output is 0.
- R2: In preset mode an up event raises the count by one only while it is below 60. At 60 an up leaves the count at 60.
- R3: In preset mode a down event lowers the count by one only while it is above 1. At 1 a down leaves the count at 1.
- R4: In preset mode an arm event clears the code register to all zeros and sets the timing output to 1, one cycle later. The count is unchanged.
- R5: In timing mode an up event shifts the code register left by one and places a 1 in bit 0. A down event does the same with a 0. The bit shifted out of bit 7 is lost, and the count is unchanged.
- R6: In timing mode an arm event returns to preset mode, keeping the remaining count, only when the code equals CANCEL_CODE (default 8'h0D). With any other code the arm event leaves the mode and the count unchanged.
- R7: In timing mode a tick whose fine value is 0 lowers the count by one. A tick with a fine value from 1 to 9 has no effect.
- R8: In preset mode tick events have no effect on the count or the mode.
- R9: When a tick lowers the count from 1 to 0, the expiry output is 1 for exactly one cycle. In that same cycle the timing output is 0 and the count output shows 10.
- R10: In timing mode a button event and a whole-second tick in the same cycle both take effect. An expiring tick takes precedence over a cancelling arm in the same cycle.
- R11: When several buttons strobe in the same cycle only one acts, with arm first, then up, then down.
- R12: Every change to the count, mode or expiry output appears in the cycle after the event that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_i | input | 1 | Up button strobe |
| down_i | input | 1 | Down button strobe |
| arm_i | input | 1 | Arm button strobe |
| tick_i | input | 1 | Tenth-of-a-second tick strobe |
| tick_fine_i | input | 4 | Fine value carried by the tick (0 to 9) |
| count_o | output | 6 | Current count of seconds |
| timing_o | output | 1 | 1 while counting down, 0 in preset mode |
| expire_o | output | 1 | One-cycle pulse when the countdown reaches zero |

## Verification
In timing mode, one cycle can carry both a code-entry button and a whole-second tick. These two functions write separate registers, so both must take effect. The bench strobes up together with a fine-0 tick and checks that the count drops at once. It then completes the cancel code and presses arm. A return to preset mode proves the bit was also shifted in. In the second case the bench loads the correct code, lets the count reach 1, and then strobes arm together with the final tick. Expiry must win: the bench expects the pulse, preset mode and a reloaded count of 10, not a cancel that keeps a count of 1.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  typedef enum logic {
    MODE_PRESET = 1'b0,
    MODE_RUN    = 1'b1
  } cdt_mode_t;
endpackage

// File: rtl/cdt_rst_sync.sv
module cdt_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = sync_q[STAGES-1];
endmodule

// File: rtl/cdt_count.sv
module cdt_count #(
  parameter int W    = 6,
  parameter int MIN  = 1,
  parameter int MAX  = 60,
  parameter int INIT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] count_o,
  output logic         at_min_o,
  output logic         at_max_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_en;

  // load beats dec beats inc
  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load_i | inc_i | dec_i;
    if (load_i)     cnt_d = W'(INIT);
    else if (dec_i) cnt_d = cnt_q - W'(1);
    else if (inc_i) cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= W'(INIT);
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count_o  = cnt_q;
  assign at_min_o = (cnt_q <= W'(MIN));
  assign at_max_o = (cnt_q >= W'(MAX));
endmodule

// File: rtl/cdt_code.sv
module cdt_code #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         shift_i,
  input  logic         bit_i,
  output logic [W-1:0] code_o
);
  logic [W-1:0] code_q, code_d;
  logic         code_en;

  always_comb begin
    code_en = clr_i | shift_i;
    if (clr_i) code_d = '0;
    else       code_d = {code_q[W-2:0], bit_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       code_q <= '0;
    else if (code_en) code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/cdt_ctrl.sv
module cdt_ctrl
  import cdt_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start_i,
  input  logic      cancel_i,
  input  logic      last_i,
  output cdt_mode_t mode_o,
  output logic      expire_o
);
  cdt_mode_t mode_q, mode_d;
  logic      exp_q;

  always_comb begin
    mode_d = mode_q;
    if (last_i)        mode_d = MODE_PRESET;
    else if (cancel_i) mode_d = MODE_PRESET;
    else if (start_i)  mode_d = MODE_RUN;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_PRESET;
      exp_q  <= 1'b0;
    end else begin
      mode_q <= mode_d;
      exp_q  <= last_i;
    end
  end

  assign mode_o   = mode_q;
  assign expire_o = exp_q;
endmodule

// File: rtl/cancel_countdown.sv
module cancel_countdown
  import cdt_pkg::*;
#(
  parameter int               CODE_W      = 8,
  parameter logic [CODE_W-1:0] CANCEL_CODE = 8'h0D,
  parameter int               CNT_W       = 6,
  parameter int               CNT_MIN     = 1,
  parameter int               CNT_MAX     = 60,
  parameter int               CNT_INIT    = 10,
  parameter int               FINE_W      = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              up_i,
  input  logic              down_i,
  input  logic              arm_i,
  input  logic              tick_i,
  input  logic [FINE_W-1:0] tick_fine_i,
  output logic [CNT_W-1:0]  count_o,
  output logic              timing_o,
  output logic              expire_o
);
  logic              rst_n_s;
  cdt_mode_t         mode;
  logic [CODE_W-1:0] code_q;
  logic              at_min, at_max;
  logic              arm_ev, up_ev, dn_ev, run, sec_tick, last, cancel, start;
  logic              inc, dec;

  cdt_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_n_s)
  );

  // one button per cycle: arm, then up, then down
  assign arm_ev   = arm_i;
  assign up_ev    = up_i & ~arm_i;
  assign dn_ev    = down_i & ~arm_i & ~up_i;
  assign run      = (mode == MODE_RUN);
  assign sec_tick = run & tick_i & (tick_fine_i == '0);
  assign last     = sec_tick & at_min;
  assign cancel   = run & arm_ev & (code_q == CANCEL_CODE);
  assign start    = ~run & arm_ev;
  assign inc      = ~run & up_ev & ~at_max;
  assign dec      = (~run & dn_ev & ~at_min) | sec_tick;

  cdt_count #(.W(CNT_W), .MIN(CNT_MIN), .MAX(CNT_MAX), .INIT(CNT_INIT)) u_count (
    .clk(clk), .rst_n(rst_n_s), .load_i(last), .inc_i(inc), .dec_i(dec),
    .count_o(count_o), .at_min_o(at_min), .at_max_o(at_max)
  );

  cdt_code #(.W(CODE_W)) u_code (
    .clk(clk), .rst_n(rst_n_s), .clr_i(start), .shift_i(run & (up_ev | dn_ev)),
    .bit_i(up_ev), .code_o(code_q)
  );

  cdt_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n_s), .start_i(start), .cancel_i(cancel), .last_i(last),
    .mode_o(mode), .expire_o(expire_o)
  );

  assign timing_o = run;
endmodule

// File: rtl/cancel_countdown_chk.sv
module cancel_countdown_chk #(
  parameter int CODE_W   = 8,
  parameter int CNT_W    = 6,
  parameter int CNT_MIN  = 1,
  parameter int CNT_MAX  = 60,
  parameter int CNT_INIT = 10,
  parameter int FINE_W   = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              up_i,
  input logic              down_i,
  input logic              arm_i,
  input logic              tick_i,
  input logic [FINE_W-1:0] tick_fine_i,
  input logic [CNT_W-1:0]  count_o,
  input logic              timing_o,
  input logic              expire_o,
  input logic [CODE_W-1:0] code_q
);
  // R2 R3
  count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o >= CNT_W'(CNT_MIN)) && (count_o <= CNT_W'(CNT_MAX)));

  // R9
  expire_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> !expire_o);

  // R9
  expire_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |-> (!timing_o && count_o == CNT_W'(CNT_INIT)));

  // R8
  preset_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing_o && tick_i && !up_i && !down_i && !arm_i) |=> ($stable(count_o) && !timing_o));

  // R4
  arm_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!timing_o && arm_i) |=> (timing_o && code_q == '0));

  // R5
  shift_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_o && up_i && !arm_i) |=> (code_q == {$past(code_q[CODE_W-2:0]), 1'b1}));

  // R7
  fine_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (timing_o && tick_i && tick_fine_i != '0 && !up_i && !down_i && !arm_i)
      |=> $stable(count_o));
endmodule

bind cancel_countdown cancel_countdown_chk #(
  .CODE_W(CODE_W), .CNT_W(CNT_W), .CNT_MIN(CNT_MIN), .CNT_MAX(CNT_MAX),
  .CNT_INIT(CNT_INIT), .FINE_W(FINE_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .up_i(up_i), .down_i(down_i), .arm_i(arm_i),
  .tick_i(tick_i), .tick_fine_i(tick_fine_i), .count_o(count_o),
  .timing_o(timing_o), .expire_o(expire_o), .code_q(code_q)
);

// File: tb/cancel_countdown_tb.sv
`timescale 1ns/1ps
module cancel_countdown_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       up_i, down_i, arm_i, tick_i;
  logic [3:0] tick_fine_i;
  logic [5:0] count_o;
  logic       timing_o, expire_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  cancel_countdown u_dut (
    .clk(clk), .rst_n(rst_n), .up_i(up_i), .down_i(down_i), .arm_i(arm_i),
    .tick_i(tick_i), .tick_fine_i(tick_fine_i), .count_o(count_o),
    .timing_o(timing_o), .expire_o(expire_o)
  );

  // {up, down, arm, tick, fine, exp_count, exp_timing, exp_expire, req}
  typedef struct packed {
    logic       up;
    logic       dn;
    logic       arm;
    logic       tick;
    logic [3:0] fine;
    logic [5:0] cnt;
    logic       tim;
    logic       exp;
    logic [3:0] req;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 6'd11, 1'b0, 1'b0, 4'd2},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 6'd10, 1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 6'd9,  1'b0, 1'b0, 4'd3},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 6'd9,  1'b0, 1'b0, 4'd8},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 6'd9,  1'b1, 1'b0, 4'd4},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 6'd9,  1'b1, 1'b0, 4'd5},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 6'd9,  1'b1, 1'b0, 4'd5},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 6'd9,  1'b1, 1'b0, 4'd5},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd3, 6'd9,  1'b1, 1'b0, 4'd7},
    '{1'b0, 1'b0, 1'b0, 1'b1, 4'd0, 6'd8,  1'b1, 1'b0, 4'd7},
    '{1'b0, 1'b1, 1'b0, 1'b0, 4'd0, 6'd8,  1'b1, 1'b0, 4'd5},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 6'd8,  1'b1, 1'b0, 4'd6},
    '{1'b1, 1'b0, 1'b0, 1'b0, 4'd0, 6'd8,  1'b1, 1'b0, 4'd5},
    '{1'b0, 1'b0, 1'b1, 1'b0, 4'd0, 6'd8,  1'b0, 1'b0, 4'd6}
  };

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // inputs change just after a falling edge; results are read at the next falling edge
  task automatic step(input logic u, input logic d, input logic a, input logic t,
                      input logic [3:0] f);
    up_i = u; down_i = d; arm_i = a; tick_i = t; tick_fine_i = f;
    @(negedge clk);
    up_i = 1'b0; down_i = 1'b0; arm_i = 1'b0; tick_i = 1'b0; tick_fine_i = 4'd0;
  endtask

  task automatic expect_out(input string req, input int cnt, input int tim, input int ex);
    chk(req, "count", int'(count_o), cnt);
    chk(req, "timing", int'(timing_o), tim);
    chk(req, "expire", int'(expire_o), ex);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    up_i = 1'b0; down_i = 1'b0; arm_i = 1'b0; tick_i = 1'b0; tick_fine_i = 4'd0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    expect_out("R1", 10, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_out("R1", 10, 0, 0);

    // table walk, R12 timing: each row checked one cycle after its event
    for (int i = 0; i < NV; i++) begin
      step(VEC[i].up, VEC[i].dn, VEC[i].arm, VEC[i].tick, VEC[i].fine);
      expect_out($sformatf("R%0d/R12 row%0d", VEC[i].req, i),
                 int'(VEC[i].cnt), int'(VEC[i].tim), int'(VEC[i].exp));
    end

    // R2 upper limit: from 8 up to 60, then one more up
    for (int i = 0; i < 52; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    expect_out("R2", 60, 0, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    expect_out("R2", 60, 0, 0);

    // R3 lower limit
    for (int i = 0; i < 59; i++) step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    expect_out("R3", 1, 0, 0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    expect_out("R3", 1, 0, 0);

    // R11 up beats down; arm beats up
    step(1'b1, 1'b1, 1'b0, 1'b0, 4'd0);
    expect_out("R11", 2, 0, 0);
    step(1'b1, 1'b0, 1'b1, 1'b0, 4'd0);
    expect_out("R11", 2, 1, 0);

    // R10 button and whole-second tick together: both act
    step(1'b1, 1'b0, 1'b0, 1'b1, 4'd0);
    expect_out("R10", 1, 1, 0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
    expect_out("R10/R6", 1, 0, 0);

    // R10 expiry takes precedence over a cancelling arm
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    expect_out("R2", 2, 0, 0);
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    step(1'b0, 1'b1, 1'b0, 1'b0, 4'd0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 4'd0);
    step(1'b0, 1'b0, 1'b0, 1'b1, 4'd0);
    expect_out("R7", 1, 1, 0);
    step(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    expect_out("R10/R9", 10, 0, 1);
    step(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    expect_out("R9", 10, 0, 0);

    // R1 reset in timing mode
    step(1'b0, 1'b0, 1'b1, 1'b0, 4'd0);
    expect_out("R4", 10, 1, 0);
    rst_n = 1'b0;
    @(negedge clk);
    expect_out("R1", 10, 0, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule